// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block turns a serial bit stream into a parallel word. Bits arrive on a serial input and move along a shift stage on each rising edge of a dedicated shift clock. A second, independent storage clock copies the whole shift stage into an output latch in one step. The parallel port therefore shows only complete words, never the partial patterns seen while a word is being shifted.

The parallel port can be released to high impedance with an active-low enable. Here that state is modelled as logic with a separate valid flag. An asynchronous active-low clear empties the shift stage and leaves the latch untouched.

The last stage of the shift register is also brought out as a cascade output. Any number of instances can be chained by feeding each cascade output into the next serial input. All instances share one serial data line, one shift clock and one storage clock.

Top module: `latched_sipo`

## Requirements
- R1: On each rising edge of `sh_clk`, `ser_in` enters stage 0 and every stage i (0 to 6) moves into stage i+1.
- R2: `cas_out` always equals stage 7. After eight `sh_clk` edges it presents the first bit that was shifted in.
- R3: A rising edge of `st_clk` copies all 8 stages into the storage register at once. `par_out[i]` shows stage i as it was at that edge. Shift edges alone never change `par_out`.
- R4: When `sh_clk` and `st_clk` rise together, the storage register captures the shift-stage contents from before that shift edge.
- R5: When `oe_n` is 1, `par_vld` is 0 and `par_out` is all zeros (the high-impedance state). When `oe_n` is 0, `par_vld` is 1 and `par_out` equals the storage register.
- R6: `oe_n` has no effect on the shift stage, the storage register or `cas_out`.
- R7: While `clr_n` is 0, the shift stage is zero at once, without a clock edge, so `cas_out` is 0. The storage register keeps its value.
- R8: With two instances chained (`cas_out` of the first feeding `ser_in` of the second) on shared clocks, 16 shift edges followed by one store leave the first 8 bits sent in the second instance and the last 8 bits in the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sh_clk | input | 1 | Shift clock, rising edge active |
| st_clk | input | 1 | Storage clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear of the shift stage, active low |
| ser_in | input | 1 | Serial data input |
| oe_n | input | 1 | Parallel output enable, active low |
| par_out | output | 8 | Parallel output word (all zeros while released) |
| par_vld | output | 1 | High while the parallel port drives |
| cas_out | output | 1 | Cascade serial output (stage 7) |

## Verification
Words are shifted in most significant bit first. The patterns used are 0xA5, 0x5A, 0x3C, 0xFF and an alternating stream, so that any stage swap, bit reversal or off-by-one shift gives a different parallel word. The cascade output is compared after every edge, which separates a tap on the wrong stage from a correct one. Coincident shift and store edges show whether the latch takes the old or the new shift contents. A 16-bit stream through two chained instances shows that the first byte sent lands in the second device and not the first.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned LSR_DEF_WIDTH = 8;

  // Encoding of the active-low enable pin
  typedef enum logic {
    DRV_ON  = 1'b0,
    DRV_HIZ = 1'b1
  } drive_e;
endpackage

// File: rtl/lsr_shift_stage.sv
module lsr_shift_stage #(
  parameter int unsigned WIDTH = lsr_pkg::LSR_DEF_WIDTH
) (
  input  logic             sh_clk,
  input  logic             clr_n,
  input  logic             din,
  output logic [WIDTH-1:0] stages,
  output logic             tail
);
  function automatic logic [WIDTH-1:0] shift_next(input logic [WIDTH-1:0] cur,
                                                  input logic             bit_in);
    return {cur[WIDTH-2:0], bit_in};
  endfunction

  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) stages <= '0;
    else        stages <= shift_next(stages, din);
  end

  assign tail = stages[WIDTH-1];
endmodule

// File: rtl/lsr_store_latch.sv
module lsr_store_latch #(
  parameter int unsigned WIDTH = lsr_pkg::LSR_DEF_WIDTH
) (
  input  logic             st_clk,
  input  logic [WIDTH-1:0] snap_in,
  output logic [WIDTH-1:0] held
);
  always_ff @(posedge st_clk) begin
    held <= snap_in;
  end
endmodule

// File: rtl/lsr_out_gate.sv
module lsr_out_gate #(
  parameter int unsigned WIDTH = lsr_pkg::LSR_DEF_WIDTH
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] pins,
  output logic             drive
);
  import lsr_pkg::*;
  drive_e mode;

  assign mode  = drive_e'(oe_n);
  assign drive = (mode == DRV_ON);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pins[i] = drive & word[i];
  end
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo #(
  parameter int unsigned WIDTH = lsr_pkg::LSR_DEF_WIDTH
) (
  input  logic             sh_clk,
  input  logic             st_clk,
  input  logic             clr_n,
  input  logic             ser_in,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_out,
  output logic             par_vld,
  output logic             cas_out
);
  logic [WIDTH-1:0] sreg_q;
  logic [WIDTH-1:0] stor_q;

  lsr_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .sh_clk (sh_clk),
    .clr_n  (clr_n),
    .din    (ser_in),
    .stages (sreg_q),
    .tail   (cas_out)
  );

  lsr_store_latch #(.WIDTH(WIDTH)) u_store (
    .st_clk  (st_clk),
    .snap_in (sreg_q),
    .held    (stor_q)
  );

  lsr_out_gate #(.WIDTH(WIDTH)) u_gate (
    .oe_n  (oe_n),
    .word  (stor_q),
    .pins  (par_out),
    .drive (par_vld)
  );
endmodule

// File: rtl/lsr_chk.sv
module lsr_chk #(
  parameter int unsigned WIDTH = lsr_pkg::LSR_DEF_WIDTH
) (
  input logic             sh_clk,
  input logic             st_clk,
  input logic             clr_n,
  input logic             ser_in,
  input logic             oe_n,
  input logic [WIDTH-1:0] sreg_q,
  input logic [WIDTH-1:0] stor_q,
  input logic [WIDTH-1:0] par_out,
  input logic             par_vld,
  input logic             cas_out
);
  // Set once a shift edge has been taken with no clear since
  logic seen_q;
  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R1
  shift_move_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
    seen_q |-> sreg_q == {$past(sreg_q[WIDTH-2:0]), $past(ser_in)});

  // R2
  cascade_tap_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
    seen_q |-> cas_out == $past(sreg_q[WIDTH-2]));

  // R3
  store_copy_chk: assert property (@(posedge st_clk) disable iff (!clr_n)
    1'b1 |=> stor_q == $past(sreg_q));

  // R5
  release_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
    oe_n |-> (!par_vld && par_out == '0));

  // R5
  drive_chk: assert property (@(posedge sh_clk) disable iff (!clr_n)
    !oe_n |-> (par_vld && par_out == stor_q));

  // R7
  clear_empty_chk: assert property (@(posedge st_clk)
    !clr_n |-> (sreg_q == '0 && !cas_out));
endmodule

bind latched_sipo lsr_chk #(.WIDTH(WIDTH)) u_chk (
  .sh_clk  (sh_clk),
  .st_clk  (st_clk),
  .clr_n   (clr_n),
  .ser_in  (ser_in),
  .oe_n    (oe_n),
  .sreg_q  (sreg_q),
  .stor_q  (stor_q),
  .par_out (par_out),
  .par_vld (par_vld),
  .cas_out (cas_out)
);

// File: tb/latched_sipo_test.sv
module latched_sipo_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic       sh_clk = 0, st_clk = 0, clr_n = 1, ser_in = 0, oe_n = 0;
  logic [7:0] par_a, par_b;
  logic       vld_a, vld_b, cas_a, cas_b;
  int         errors = 0, checks = 0;
  logic [7:0] exp_a = '0;

  latched_sipo uut (
    .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .ser_in(ser_in),
    .oe_n(oe_n), .par_out(par_a), .par_vld(vld_a), .cas_out(cas_a));

  latched_sipo uut2 (
    .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .ser_in(cas_a),
    .oe_n(oe_n), .par_out(par_b), .par_vld(vld_b), .cas_out(cas_b));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_sh(input logic d);
    ser_in = d;
    #HALF sh_clk = 1;
    exp_a = {exp_a[6:0], d};
    #HALF sh_clk = 0;
  endtask

  task automatic pulse_st();
    #HALF st_clk = 1;
    #HALF st_clk = 0;
  endtask

  // Sends MSB first and checks the cascade bit after every edge
  task automatic send_byte(input logic [7:0] b, input string req);
    for (int i = 7; i >= 0; i--) begin
      pulse_sh(b[i]);
      check(req, {7'd0, cas_a}, {7'd0, exp_a[7]});
    end
  endtask

  task automatic t_reset();
    clr_n = 0; #HALF;
    check("R7 cascade zero in clear", {7'd0, cas_a}, 8'h00);
    clr_n = 1; exp_a = '0;
    pulse_st();
    check("R3 reset word", par_a, 8'h00);
    check("R5 valid when enabled", {7'd0, vld_a}, 8'h01);
  endtask

  task automatic t_shift_store();
    send_byte(8'hA5, "R2 cascade A5");
    check("R3 no change while shifting", par_a, 8'h00);
    check("R2 first bit at tail", {7'd0, cas_a}, 8'h01);
    pulse_st();
    check("R3 R1 store A5", par_a, 8'hA5);
    send_byte(8'h5A, "R2 cascade 5A");
    check("R3 still A5 before store", par_a, 8'hA5);
    pulse_st();
    check("R1 store 5A", par_a, 8'h5A);
  endtask

  task automatic t_coincident();
    // shift stage holds 5A; both clocks rise together
    ser_in = 1;
    #HALF; sh_clk = 1; st_clk = 1; exp_a = {exp_a[6:0], 1'b1};
    #HALF; sh_clk = 0; st_clk = 0;
    check("R4 old contents captured", par_a, 8'h5A);
    pulse_st();
    check("R4 new contents on next store", par_a, 8'hB5);
  endtask

  task automatic t_enable();
    oe_n = 1; #HALF;
    check("R5 released word", par_a, 8'h00);
    check("R5 released valid", {7'd0, vld_a}, 8'h00);
    send_byte(8'h3C, "R6 cascade while released");
    pulse_st();
    check("R5 still released after store", par_a, 8'h00);
    oe_n = 0; #HALF;
    check("R6 store taken while released", par_a, 8'h3C);
    check("R5 valid back", {7'd0, vld_a}, 8'h01);
  endtask

  task automatic t_clear();
    send_byte(8'hFF, "R2 cascade FF");
    clr_n = 0; #1;
    check("R7 async cascade clear", {7'd0, cas_a}, 8'h00);
    check("R7 storage kept", par_a, 8'h3C);
    clr_n = 1; exp_a = '0; #HALF;
    pulse_st();
    check("R7 shift stage emptied", par_a, 8'h00);
  endtask

  task automatic t_cascade();
    for (int i = 7; i >= 0; i--) pulse_sh(1'(8'hC3 >> i));
    for (int i = 7; i >= 0; i--) pulse_sh(1'(8'h96 >> i));
    pulse_st();
    check("R8 first device last byte", par_a, 8'h96);
    check("R8 second device first byte", par_b, 8'hC3);
    check("R8 second tail", {7'd0, cas_b}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #HALF;
    t_reset();
    t_shift_store();
    t_coincident();
    t_enable();
    t_clear();
    t_cascade();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule